// File: doc/BRIEF.md
# Speculative Load Poison Guard

This block sits next to a load unit that issues speculative loads which must never trap. For every load request it takes the base register value and index, either a displacement register (value and index) or a signed immediate, the target register index, a size code and a select between the integer and floating-point register files. It forms the effective address and checks two alignments: the memory address against the access size, and the target register index against the width of multi-register loads. It then decides whether the load may go ahead.

A misaligned speculative load does not trap. Instead the target register is marked as poisoned in a 64-entry flag vector kept for each register file. When the request has no fault, poison already present on a source register is passed on to the target and the load is held back. A clean request clears the target's poison. When recording is switched on, each legal request also takes a free slot in a small pool of syndrome entries and stores its effective address in that slot. A slot is handed back through a per-slot release input. All results appear one clock after the request.

Top module: `spec_load_guard`

## Requirements
- R1: The effective address is base plus displacement value when `disp_use_i` is 1, and otherwise base plus `imm_i` sign-extended from 12 bits. The recorded address shows which was used.
- R2: Size codes are 0 and 1 for byte (unsigned, signed), 2 and 3 for halfword, 4 for word, 5 for doubleword and 6 for quadword. The address fault flag is set when the effective address has any low bits set under the mask for that size: none for byte, bit 0 for halfword, bits 1:0 for word, bits 2:0 for doubleword, bits 3:0 for quadword.
- R3: The register fault flag is set for a doubleword load with an odd target index, and for a quadword load whose target index is not a multiple of 4. No other size raises it.
- R4: On an address or register fault, the target's poison bit is set in the file chosen by `is_fp_i` (0 = integer), and `issue_o` stays 1.
- R5: On a fault-free request, the target bit is set and `issue_o` is 0 if the chosen file has poison on the base index, or on the displacement index when `disp_use_i` is 1. Otherwise the target bit is cleared and `issue_o` is 1. The displacement index is ignored when `disp_use_i` is 0.
- R6: When `rec_ctrl_valid_i` and `rec_ctrl_en_i` are both 1 on a legal request, the lowest-numbered free slot is written. Each 16-bit entry in `syn_o` is laid out as: [15] valid, [14] address valid (always 1), [13] register-misalign code, [12] address-misalign code, [11] float select, [10:9] slot index, [8:6] size code, [5:0] target index. The effective address goes to the same slot of `syn_addr_o`.
- R7: Both misalignment codes in a new entry are 0 unless the matching fault happened on that request.
- R8: When recording is requested and no slot is free, `overflow_o` is 1 for exactly one cycle and no slot changes.
- R9: Size code 7 is illegal. It sets `size_err_o`, forces `issue_o` to 0, and leaves both flag vectors and all slots unchanged.
- R10: Results appear on the cycle after the request, together with `resp_valid_o`. Only the selected file changes, and with no request neither flag vector changes.
- R11: A 1 on bit k of `slot_release_i` clears the valid bit of slot k on the next clock, which frees the slot for allocation.
- R12: After reset both flag vectors are zero, all slots are invalid and every output flag is 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Load request present |
| base_val_i | input | 32 | Base register value |
| base_idx_i | input | 6 | Base register index |
| disp_use_i | input | 1 | Use displacement register instead of immediate |
| disp_val_i | input | 32 | Displacement register value |
| disp_idx_i | input | 6 | Displacement register index |
| imm_i | input | 12 | Signed immediate |
| tgt_idx_i | input | 6 | Target register index |
| size_i | input | 3 | Access size code |
| is_fp_i | input | 1 | 1 selects float file, 0 integer file |
| rec_ctrl_valid_i | input | 1 | Recording control is valid |
| rec_ctrl_en_i | input | 1 | Recording enable bit |
| slot_release_i | input | 4 | Per-slot release of syndrome entries |
| resp_valid_o | output | 1 | Result valid for previous request |
| issue_o | output | 1 | Load may proceed |
| addr_fault_o | output | 1 | Memory address misaligned |
| reg_fault_o | output | 1 | Target register misaligned |
| size_err_o | output | 1 | Illegal size code |
| overflow_o | output | 1 | Recording requested with no free slot |
| int_flags_o | output | 64 | Integer poison flags |
| fp_flags_o | output | 64 | Float poison flags |
| syn_o | output | 64 | Four packed syndrome entries |
| syn_addr_o | output | 128 | Four recorded effective addresses |

## Verification
The bench targets poison passing through the displacement index. It covers the index being ignored when an immediate is used and honoured when it is not. A design that ORs it in unconditionally would hold back clean loads. It also covers a quadword target index that is even but not a multiple of 4, and a quadword address that is aligned to 8 but not to 16. Either one catches a mask or index check that is one bit too narrow. A negative immediate checks sign extension through the recorded address. Filling every slot and then releasing a middle one checks that allocation reuses the lowest free slot, and that an overflowing request writes nothing. An illegal size code with recording enabled must leave both flag vectors and the free slot untouched.

// File: rtl/nel_pkg.sv
package nel_pkg;
  parameter int unsigned ADDR_W     = 32;
  parameter int unsigned REG_IDX_W  = 6;
  parameter int unsigned SLOT_IDX_W = 2;
  parameter int unsigned IMM_W      = 12;
  localparam int unsigned N_REGS    = 1 << REG_IDX_W;
  localparam int unsigned N_SLOTS   = 1 << SLOT_IDX_W;
  localparam int unsigned N_FILES   = 2;

  typedef enum logic [2:0] {
    SZ_UB  = 3'd0,
    SZ_SB  = 3'd1,
    SZ_UH  = 3'd2,
    SZ_SH  = 3'd3,
    SZ_W   = 3'd4,
    SZ_D   = 3'd5,
    SZ_Q   = 3'd6,
    SZ_BAD = 3'd7
  } size_e;

  typedef struct packed {
    logic                  valid;
    logic                  addr_ok;
    logic                  reg_code;
    logic                  mem_code;
    logic                  is_fp;
    logic [SLOT_IDX_W-1:0] slot;
    logic [2:0]            size;
    logic [REG_IDX_W-1:0]  tgt;
  } syn_t;

  localparam int unsigned SYN_W = $bits(syn_t);
endpackage

// File: rtl/nel_addr_check.sv
module nel_addr_check
  import nel_pkg::*;
(
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [ADDR_W-1:0]    disp_i,
  input  logic [IMM_W-1:0]     imm_i,
  input  logic                 disp_use_i,
  input  logic [2:0]           size_i,
  input  logic [REG_IDX_W-1:0] tgt_i,
  output logic [ADDR_W-1:0]    ea_o,
  output logic                 addr_fault_o,
  output logic                 reg_fault_o,
  output logic                 size_bad_o
);
  logic [ADDR_W-1:0] imm_ext;
  logic [3:0]        align_mask;

  assign imm_ext = {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign ea_o    = base_i + (disp_use_i ? disp_i : imm_ext);

  always_comb begin
    align_mask  = 4'h0;
    reg_fault_o = 1'b0;
    size_bad_o  = 1'b0;
    unique case (size_e'(size_i))
      SZ_UB, SZ_SB: align_mask = 4'h0;
      SZ_UH, SZ_SH: align_mask = 4'h1;
      SZ_W:         align_mask = 4'h3;
      SZ_D: begin
        align_mask  = 4'h7;
        reg_fault_o = tgt_i[0];
      end
      SZ_Q: begin
        align_mask  = 4'hf;
        reg_fault_o = |tgt_i[1:0];
      end
      default:      size_bad_o = 1'b1;
    endcase
  end

  assign addr_fault_o = |(ea_o[3:0] & align_mask);
endmodule

// File: rtl/nel_flag_file.sv
module nel_flag_file
  import nel_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic                 fault_i,
  input  logic                 disp_use_i,
  input  logic [REG_IDX_W-1:0] base_idx_i,
  input  logic [REG_IDX_W-1:0] disp_idx_i,
  input  logic [REG_IDX_W-1:0] tgt_idx_i,
  output logic                 poison_o,
  output logic [N_REGS-1:0]    flags_o
);
  logic [N_REGS-1:0] flags_q;

  assign poison_o = flags_q[base_idx_i] | (disp_use_i & flags_q[disp_idx_i]);
  assign flags_o  = flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (upd_i) flags_q[tgt_idx_i] <= fault_i | poison_o;
  end

  a_r4_fault_poisons: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && fault_i) |=> flags_q[$past(tgt_idx_i)]);
  a_r5_clean_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !fault_i && !flags_q[base_idx_i] && !(disp_use_i && flags_q[disp_idx_i]))
      |=> !flags_q[$past(tgt_idx_i)]);
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_q));
endmodule

// File: rtl/nel_syn_pool.sv
module nel_syn_pool
  import nel_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_i,
  input  syn_t                      entry_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [N_SLOTS-1:0]        release_i,
  output logic [N_SLOTS*SYN_W-1:0]  syn_o,
  output logic [N_SLOTS*ADDR_W-1:0] addr_o,
  output logic                      ovf_o
);
  syn_t [N_SLOTS-1:0]              syn_q;
  logic [N_SLOTS-1:0][ADDR_W-1:0]  addr_q;
  logic [N_SLOTS-1:0]              valid_q;
  logic [N_SLOTS-1:0]              grant;
  logic                            any_free;
  logic                            ovf_q;

  always_comb begin
    grant    = '0;
    any_free = 1'b0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        any_free = 1'b1;
      end
    end
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    assign valid_q[s] = syn_q[s].valid;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        syn_q[s]  <= '0;
        addr_q[s] <= '0;
      end else if (alloc_i && grant[s]) begin
        syn_q[s]       <= entry_i;
        syn_q[s].valid <= 1'b1;
        syn_q[s].slot  <= SLOT_IDX_W'(s);
        addr_q[s]      <= addr_i;
      end else if (release_i[s]) begin
        syn_q[s].valid <= 1'b0;
      end
    end

    assign syn_o[s*SYN_W +: SYN_W]    = syn_q[s];
    assign addr_o[s*ADDR_W +: ADDR_W] = addr_q[s];

    a_r11_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (release_i[s] && valid_q[s]) |=> !valid_q[s]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= alloc_i && !any_free;
  end
  assign ovf_o = ovf_q;

  a_r6_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  a_r8_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && (&valid_q) && !(|release_i)) |=> (ovf_q && $stable(syn_q) && $stable(addr_q)));
  a_r8_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_i |=> !ovf_q);
endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard
  import nel_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [ADDR_W-1:0]         base_val_i,
  input  logic [REG_IDX_W-1:0]      base_idx_i,
  input  logic                      disp_use_i,
  input  logic [ADDR_W-1:0]         disp_val_i,
  input  logic [REG_IDX_W-1:0]      disp_idx_i,
  input  logic [IMM_W-1:0]          imm_i,
  input  logic [REG_IDX_W-1:0]      tgt_idx_i,
  input  logic [2:0]                size_i,
  input  logic                      is_fp_i,
  input  logic                      rec_ctrl_valid_i,
  input  logic                      rec_ctrl_en_i,
  input  logic [N_SLOTS-1:0]        slot_release_i,
  output logic                      resp_valid_o,
  output logic                      issue_o,
  output logic                      addr_fault_o,
  output logic                      reg_fault_o,
  output logic                      size_err_o,
  output logic                      overflow_o,
  output logic [N_REGS-1:0]         int_flags_o,
  output logic [N_REGS-1:0]         fp_flags_o,
  output logic [N_SLOTS*SYN_W-1:0]  syn_o,
  output logic [N_SLOTS*ADDR_W-1:0] syn_addr_o
);
  logic [ADDR_W-1:0]         ea;
  logic                      addr_fault, reg_fault, size_bad, fault;
  logic [N_FILES-1:0]        upd, poison;
  logic [N_FILES-1:0][N_REGS-1:0] flags;
  logic                      poison_sel, issue_d, rec_req;
  syn_t                      entry;

  nel_addr_check u_addr (
    .base_i       (base_val_i),
    .disp_i       (disp_val_i),
    .imm_i        (imm_i),
    .disp_use_i   (disp_use_i),
    .size_i       (size_i),
    .tgt_i        (tgt_idx_i),
    .ea_o         (ea),
    .addr_fault_o (addr_fault),
    .reg_fault_o  (reg_fault),
    .size_bad_o   (size_bad)
  );

  assign fault = addr_fault | reg_fault;

  for (genvar f = 0; f < N_FILES; f++) begin : g_file
    assign upd[f] = req_valid_i && !size_bad && (is_fp_i == f[0]);
    nel_flag_file u_flags (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .upd_i      (upd[f]),
      .fault_i    (fault),
      .disp_use_i (disp_use_i),
      .base_idx_i (base_idx_i),
      .disp_idx_i (disp_idx_i),
      .tgt_idx_i  (tgt_idx_i),
      .poison_o   (poison[f]),
      .flags_o    (flags[f])
    );
  end

  assign int_flags_o = flags[0];
  assign fp_flags_o  = flags[1];
  assign poison_sel  = poison[is_fp_i];
  assign issue_d     = !size_bad && (fault || !poison_sel);
  assign rec_req     = req_valid_i && rec_ctrl_valid_i && rec_ctrl_en_i && !size_bad;

  always_comb begin
    entry          = '0;
    entry.valid    = 1'b1;
    entry.addr_ok  = 1'b1;
    entry.reg_code = reg_fault;
    entry.mem_code = addr_fault;
    entry.is_fp    = is_fp_i;
    entry.size     = size_i;
    entry.tgt      = tgt_idx_i;
  end

  nel_syn_pool u_pool (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alloc_i   (rec_req),
    .entry_i   (entry),
    .addr_i    (ea),
    .release_i (slot_release_i),
    .syn_o     (syn_o),
    .addr_o    (syn_addr_o),
    .ovf_o     (overflow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      issue_o      <= 1'b0;
      addr_fault_o <= 1'b0;
      reg_fault_o  <= 1'b0;
      size_err_o   <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i;
      issue_o      <= req_valid_i && issue_d;
      addr_fault_o <= req_valid_i && addr_fault;
      reg_fault_o  <= req_valid_i && reg_fault;
      size_err_o   <= req_valid_i && size_bad;
    end
  end

  a_r9_illegal_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && size_err_o) |-> (!issue_o && !addr_fault_o && !reg_fault_o));
  a_r4_fault_issues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && (addr_fault_o || reg_fault_o)) |-> issue_o);
  a_r10_no_resp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> (!issue_o && !size_err_o));
  a_r9_illegal_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && size_bad) |=> ($stable(int_flags_o) && $stable(fp_flags_o)));
endmodule

// File: tb/spec_load_guard_tb.sv
module spec_load_guard_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic [31:0]  base_v = '0, disp_v = '0;
  logic [5:0]   base_ix = '0, disp_ix = '0, tgt_ix = '0;
  logic         use_d = 1'b0, fp_sel = 1'b0;
  logic [11:0]  imm = '0;
  logic [2:0]   sz = '0;
  logic         cv = 1'b0, ce = 1'b0;
  logic [3:0]   rel = '0;
  logic         resp_v, iss, af, rf, serr, ovf;
  logic [63:0]  intf, fpf, syn;
  logic [127:0] saddr;

  int n_chk = 0, n_bad = 0;
  logic [63:0] int_m = '0, fp_m = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spec_load_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req),
    .base_val_i(base_v), .base_idx_i(base_ix), .disp_use_i(use_d),
    .disp_val_i(disp_v), .disp_idx_i(disp_ix), .imm_i(imm),
    .tgt_idx_i(tgt_ix), .size_i(sz), .is_fp_i(fp_sel),
    .rec_ctrl_valid_i(cv), .rec_ctrl_en_i(ce), .slot_release_i(rel),
    .resp_valid_o(resp_v), .issue_o(iss), .addr_fault_o(af), .reg_fault_o(rf),
    .size_err_o(serr), .overflow_o(ovf), .int_flags_o(intf), .fp_flags_o(fpf),
    .syn_o(syn), .syn_addr_o(saddr)
  );

  typedef struct packed {
    logic [31:0] b; logic [31:0] d; logic [11:0] im; logic ud;
    logic [5:0] bi; logic [5:0] di; logic [5:0] t; logic [2:0] sz; logic fp;
    logic ei; logic eaf; logic erf;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{32'h1000, 32'h0, 12'h000, 1'b0, 6'd0,  6'd0, 6'd3,  3'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h1001, 32'h0, 12'h000, 1'b0, 6'd0,  6'd0, 6'd4,  3'd2, 1'b0, 1'b1, 1'b1, 1'b0},
    '{32'h1000, 32'h2, 12'h000, 1'b1, 6'd0,  6'd0, 6'd7,  3'd4, 1'b0, 1'b1, 1'b1, 1'b0},
    '{32'h1004, 32'h0, 12'hffc, 1'b0, 6'd10, 6'd0, 6'd8,  3'd4, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h1008, 32'h0, 12'h000, 1'b0, 6'd0,  6'd0, 6'd9,  3'd5, 1'b0, 1'b1, 1'b0, 1'b1},
    '{32'h1010, 32'h0, 12'h000, 1'b0, 6'd0,  6'd0, 6'd6,  3'd6, 1'b0, 1'b1, 1'b0, 1'b1},
    '{32'h1018, 32'h0, 12'h000, 1'b0, 6'd0,  6'd0, 6'd8,  3'd6, 1'b0, 1'b1, 1'b1, 1'b0},
    '{32'h1000, 32'h0, 12'h000, 1'b0, 6'd4,  6'd0, 6'd20, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h0, 12'h000, 1'b0, 6'd3,  6'd7, 6'd21, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h1000, 32'h0, 12'h000, 1'b1, 6'd3,  6'd7, 6'd22, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h0, 12'h000, 1'b0, 6'd4,  6'd0, 6'd4,  3'd4, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h1001, 32'h0, 12'h000, 1'b0, 6'd0,  6'd0, 6'd30, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0},
    '{32'h1000, 32'h0, 12'h000, 1'b0, 6'd20, 6'd0, 6'd20, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1000, 32'h0, 12'h000, 1'b0, 6'd0,  6'd0, 6'd4,  3'd4, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h1003, 32'h0, 12'h000, 1'b0, 6'd0,  6'd0, 6'd1,  3'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h1002, 32'h0, 12'h000, 1'b0, 6'd9,  6'd0, 6'd2,  3'd3, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic rc, input logic mc, input logic fp,
                                     input logic [1:0] sl, input logic [2:0] s, input logic [5:0] t);
    return {1'b1, 1'b1, rc, mc, fp, sl, s, t};
  endfunction

  // Called at a negedge; returns at the negedge after the result edge.
  task automatic do_req(input vec_t v, input logic ese, input logic eov, input string tag);
    logic p;
    base_v = v.b; disp_v = v.d; imm = v.im; use_d = v.ud; base_ix = v.bi;
    disp_ix = v.di; tgt_ix = v.t; sz = v.sz; fp_sel = v.fp; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (!ese) begin
      if (v.fp) begin
        p = fp_m[v.bi] | (v.ud & fp_m[v.di]);
        fp_m[v.t] = v.eaf | v.erf | p;
      end else begin
        p = int_m[v.bi] | (v.ud & int_m[v.di]);
        int_m[v.t] = v.eaf | v.erf | p;
      end
    end
    chk(resp_v, 1'b1, {tag, " R10 resp_valid"});
    chk(iss, v.ei, {tag, " R5 issue"});
    chk(af, v.eaf, {tag, " R2 addr_fault"});
    chk(rf, v.erf, {tag, " R3 reg_fault"});
    chk(serr, ese, {tag, " R9 size_err"});
    chk(ovf, eov, {tag, " R8 overflow"});
    chk(intf, int_m, {tag, " R4 int flags"});
    chk(fpf, fp_m, {tag, " R10 fp flags"});
  endtask

  function automatic vec_t mkv(input logic [31:0] b, input logic [31:0] d, input logic [11:0] im,
                               input logic ud, input logic [5:0] t, input logic [2:0] s,
                               input logic fp, input logic eaf, input logic erf, input logic ei);
    vec_t v;
    v = '{b, d, im, ud, 6'd0, 6'd0, t, s, fp, ei, eaf, erf};
    return v;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({resp_v, iss, af, rf, serr, ovf}, 6'b0, "R12 outputs after reset");
    chk(intf, 64'h0, "R12 int flags zero");
    chk(fpf, 64'h0, "R12 fp flags zero");
    chk(syn, 64'h0, "R12 slots invalid");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) do_req(TBL[i], 1'b0, 1'b0, $sformatf("vec%0d", i));

    // R10 idle: no request leaves state alone
    @(negedge clk);
    chk(resp_v, 1'b0, "R10 idle resp");
    chk(intf, int_m, "R10 idle int flags");

    // R6 R7 R1 recording into slots 0..3
    cv = 1'b1; ce = 1'b1;
    do_req(mkv(32'h2001, 32'h0, 12'h002, 1'b0, 6'd5, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1), 1'b0, 1'b0, "rec0");
    chk(syn[15:0], mk(1'b1, 1'b1, 1'b0, 2'd0, 3'd5, 6'd5), "R7 slot0 both codes");
    chk(saddr[31:0], 32'h2003, "R1 slot0 address");
    do_req(mkv(32'h3000, 32'h10, 12'h000, 1'b1, 6'd10, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1), 1'b0, 1'b0, "rec1");
    chk(syn[31:16], mk(1'b0, 1'b0, 1'b1, 2'd1, 3'd4, 6'd10), "R6 slot1 entry");
    chk(saddr[63:32], 32'h3010, "R1 slot1 disp address");
    do_req(mkv(32'h4008, 32'h0, 12'hff8, 1'b0, 6'd11, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1), 1'b0, 1'b0, "rec2");
    chk(syn[47:32], mk(1'b0, 1'b0, 1'b0, 2'd2, 3'd0, 6'd11), "R6 slot2 entry");
    chk(saddr[95:64], 32'h4000, "R1 slot2 negative imm");
    do_req(mkv(32'h5001, 32'h0, 12'h000, 1'b0, 6'd12, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1), 1'b0, 1'b0, "rec3");
    chk(syn[63:48], mk(1'b0, 1'b1, 1'b0, 2'd3, 3'd2, 6'd12), "R7 slot3 mem code only");
    chk(saddr[127:96], 32'h5001, "R6 slot3 address");

    // R8 overflow
    do_req(mkv(32'h6000, 32'h0, 12'h000, 1'b0, 6'd13, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1), 1'b0, 1'b1, "ovf");
    chk(syn, {mk(1'b0, 1'b1, 1'b0, 2'd3, 3'd2, 6'd12), mk(1'b0, 1'b0, 1'b0, 2'd2, 3'd0, 6'd11),
              mk(1'b0, 1'b0, 1'b1, 2'd1, 3'd4, 6'd10), mk(1'b1, 1'b1, 1'b0, 2'd0, 3'd5, 6'd5)},
        "R8 slots unchanged");
    chk(saddr[127:96], 32'h5001, "R8 address unchanged");
    @(negedge clk);
    chk(ovf, 1'b0, "R8 overflow is a pulse");

    // R11 release slot 2, then reuse
    rel = 4'b0100;
    @(negedge clk);
    rel = 4'b0000;
    chk(syn[47], 1'b0, "R11 slot2 released");
    chk(syn[63], 1'b1, "R11 slot3 kept");
    do_req(mkv(32'h7000, 32'h0, 12'h000, 1'b0, 6'd16, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1), 1'b0, 1'b0, "reuse");
    chk(syn[47:32], mk(1'b0, 1'b0, 1'b0, 2'd2, 3'd6, 6'd16), "R6 lowest free slot reused");
    chk(saddr[95:64], 32'h7000, "R6 reused address");

    // R6 control not valid: no record
    rel = 4'b0001;
    @(negedge clk);
    rel = 4'b0000;
    cv = 1'b0;
    do_req(mkv(32'h8000, 32'h0, 12'h000, 1'b0, 6'd17, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1), 1'b0, 1'b0, "noctl");
    chk(syn[15], 1'b0, "R6 invalid control records nothing");

    // R9 illegal size with recording on
    cv = 1'b1;
    do_req(mkv(32'h9001, 32'h0, 12'h000, 1'b0, 6'd18, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0), 1'b1, 1'b0, "illegal");
    chk(syn[15], 1'b0, "R9 illegal size records nothing");
    chk(intf[18], 1'b0, "R9 illegal size target untouched");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule